// File: doc/BRIEF.md
# Bit-Slip Word Boundary Aligner

This block turns a serial bit stream, sampled on a fast bit clock, into parallel words that are `DF` bits wide on a slower parallel clock. The parallel clock comes from the same source as the bit clock, one parallel period to `DF` bit periods, with rising edges aligned. Bits enter MSB first, so the earliest bit of a word lands in the top output bit.

When the received words are not framed correctly, user logic in the parallel domain raises the slip input. The block synchronises that level and detects its rising edge. Each rising edge delays the word capture point by one bit period, and it does this by pausing the bit counter. A run-time wrap count `N` sets how many boundary positions are cycled through. On the `N`-th slip the block pulses a rollover flag for one parallel cycle and returns the boundary to the position it had before the first slip. It does this by pausing the counter for the number of bits that completes a full word.

Top module: `bsa_aligner`

## Requirements
- R1: `word_out` is `DF` bits wide. It holds `DF` consecutive received bits, with the earliest bit in bit `DF-1`. With a periodic input of period `DF`, every word seen is a left rotation of the repeated pattern.
- R2: Each recognised slip delays the word boundary by exactly one bit. With a periodic input, the next word is the previous word rotated left by one.
- R3: A slip level that stays high for a single parallel clock cycle is recognised as one slip.
- R4: A slip level held high for many parallel cycles counts as exactly one slip.
- R5: `rollover` is high for exactly one parallel clock cycle when the `N`-th slip since reset or since the last rollover is performed. It is low on every other cycle.
- R6: When `N` is below `DF`, the `N`-th slip puts the boundary back where it was before the first slip. With a periodic input the word then equals the word before the first slip, and the slip count restarts from zero.
- R7: A wrap count of 0 is treated as 1, and a count above `DF` is treated as `DF`. With a count of 1, every slip pulses `rollover` and leaves the word boundary unchanged.
- R8: While `rst` is high, `word_out` is zero and `rollover` is low. Reset also clears the slip count, so after reset the `N`-th new slip is the one that rolls over.
- R9: `word_out` changes only on a parallel clock edge at which a newly captured word is transferred. It holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| par_clk | input | 1 | Parallel word clock, one period per `DF` bit periods, rising edges aligned with `bit_clk` |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| ser_in | input | 1 | Serial data, one bit per `bit_clk` cycle |
| slip_req | input | 1 | Slip request level; each rising edge asks for one bit of slip |
| roll_cnt | input | RW | Wrap count `N`; 0 is treated as 1, values above `DF` as `DF` |
| word_out | output | DF | Deserialised word, synchronous to `par_clk` |
| rollover | output | 1 | One-cycle pulse when the wrap count of slips has been performed |

## Verification
The assertions check these on every cycle:
- `rollover` never lasts longer than one cycle, and it only follows a detected slip edge.
- The slip count stays within one word.
- The pending bit-clock pause never reaches a full word.
- `word_out` holds whenever no captured word is being transferred.

Only the directed scenarios can show the following, because each depends on the data and on long stretches of stimulus:
- the MSB-first framing;
- the exact one-bit rotation per slip;
- one slip for a long high level;
- the return of the boundary after a wrap;
- the clearing of the slip count by reset.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    localparam int LEN_W = 8;

    typedef logic [LEN_W-1:0] stall_len_t;

    // Slip command passed from the parallel domain to the bit domain.
    // The flip bit toggles once per slip; len is stable before the flip
    // can be seen on the far side.
    typedef struct packed {
        logic       flip;
        stall_len_t len;
    } slip_cmd_t;

    typedef enum logic [1:0] {
        SLIP_IDLE,
        SLIP_STEP,
        SLIP_WRAP
    } slip_kind_e;

    // Clamp the run-time wrap count into 1..df
    function automatic int wrap_limit(int req, int df);
        if (req < 1)  return 1;
        if (req > df) return df;
        return req;
    endfunction

    // Bit periods to pause the bit counter for a given slip kind
    function automatic stall_len_t stall_bits(slip_kind_e kind, int lim, int df);
        case (kind)
            SLIP_WRAP: return stall_len_t'(df - lim + 1);
            SLIP_STEP: return stall_len_t'(1);
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/bsa_sync.sv
module bsa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] st;

    generate
        if (STAGES < 2) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) st <= '0;
                else     st <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) st <= '0;
                else     st <= {st[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = st[STAGES-1];

endmodule

// File: rtl/bsa_slip_ctrl.sv
module bsa_slip_ctrl
    import bsa_pkg::*;
#(
    parameter int DF          = 8,
    parameter int RW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slip_lvl,
    input  logic [RW-1:0] roll_cnt,
    output slip_cmd_t     cmd,
    output logic          rollover,
    output logic          slip_rise,
    output logic [RW-1:0] slip_cnt
);

    logic       lvl_s;
    logic       lvl_d;
    int         lim;
    slip_kind_e kind;

    bsa_sync #(.STAGES(SYNC_STAGES)) u_lvl_sync (
        .clk (clk),
        .rst (rst),
        .d   (slip_lvl),
        .q   (lvl_s)
    );

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= 1'b0;
        else     lvl_d <= lvl_s;
    end

    // One event per rising edge, however long the level stays high
    assign slip_rise = lvl_s & ~lvl_d;

    always_comb begin
        lim  = wrap_limit(int'(roll_cnt), DF);
        kind = SLIP_IDLE;
        if (slip_rise) begin
            kind = ((int'(slip_cnt) + 1) >= lim) ? SLIP_WRAP : SLIP_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd      <= '0;
            rollover <= 1'b0;
            slip_cnt <= '0;
        end else begin
            rollover <= (kind == SLIP_WRAP);
            if (kind != SLIP_IDLE) begin
                cmd.flip <= ~cmd.flip;
                cmd.len  <= stall_bits(kind, lim, DF);
                slip_cnt <= (kind == SLIP_WRAP) ? '0 : slip_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bsa_deser.sv
module bsa_deser
    import bsa_pkg::*;
#(
    parameter int DF          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_in,
    input  slip_cmd_t     cmd,
    output logic [DF-1:0] hold,
    output logic          ready_flip,
    output stall_len_t    stall_left
);

    localparam int CW = (DF > 1) ? $clog2(DF) : 1;

    logic          flip_s;
    logic          flip_d;
    logic          req;
    logic [DF-1:0] shreg;
    logic [DF-1:0] next_word;
    logic [CW-1:0] bcnt;

    bsa_sync #(.STAGES(SYNC_STAGES)) u_flip_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmd.flip),
        .q   (flip_s)
    );

    always_ff @(posedge clk) begin
        if (rst) flip_d <= 1'b0;
        else     flip_d <= flip_s;
    end

    assign req       = flip_s ^ flip_d;
    assign next_word = {shreg[DF-2:0], ser_in};

    // The request cycle itself pauses the counter, so load len-1 more
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            bcnt       <= '0;
            hold       <= '0;
            ready_flip <= 1'b0;
            stall_left <= '0;
        end else begin
            shreg <= next_word;
            if (req) begin
                stall_left <= cmd.len - 1'b1;
            end else if (stall_left != '0) begin
                stall_left <= stall_left - 1'b1;
            end else if (bcnt == CW'(DF - 1)) begin
                bcnt       <= '0;
                hold       <= next_word;
                ready_flip <= ~ready_flip;
            end else begin
                bcnt <= bcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bsa_out_reg.sv
module bsa_out_reg #(
    parameter int DF          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DF-1:0] hold,
    input  logic          ready_flip,
    output logic [DF-1:0] word_out,
    output logic          word_upd
);

    logic rdy_s;
    logic rdy_d;

    bsa_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk (clk),
        .rst (rst),
        .d   (ready_flip),
        .q   (rdy_s)
    );

    always_ff @(posedge clk) begin
        if (rst) rdy_d <= 1'b0;
        else     rdy_d <= rdy_s;
    end

    assign word_upd = rdy_s ^ rdy_d;

    always_ff @(posedge clk) begin
        if (rst)           word_out <= '0;
        else if (word_upd) word_out <= hold;
    end

endmodule

// File: rtl/bsa_aligner.sv
module bsa_aligner
    import bsa_pkg::*;
#(
    parameter int DF          = 8,
    parameter int RW          = $clog2(DF + 1),
    parameter int SYNC_STAGES = 2
) (
    input  logic          bit_clk,
    input  logic          par_clk,
    input  logic          rst,
    input  logic          ser_in,
    input  logic          slip_req,
    input  logic [RW-1:0] roll_cnt,
    output logic [DF-1:0] word_out,
    output logic          rollover
);

    slip_cmd_t     cmd;
    logic          slip_rise;
    logic [RW-1:0] slip_cnt;
    logic [DF-1:0] hold;
    logic          ready_flip;
    stall_len_t    stall_left;
    logic          word_upd;

    bsa_slip_ctrl #(
        .DF          (DF),
        .RW          (RW),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_slip (
        .clk       (par_clk),
        .rst       (rst),
        .slip_lvl  (slip_req),
        .roll_cnt  (roll_cnt),
        .cmd       (cmd),
        .rollover  (rollover),
        .slip_rise (slip_rise),
        .slip_cnt  (slip_cnt)
    );

    bsa_deser #(
        .DF          (DF),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_deser (
        .clk        (bit_clk),
        .rst        (rst),
        .ser_in     (ser_in),
        .cmd        (cmd),
        .hold       (hold),
        .ready_flip (ready_flip),
        .stall_left (stall_left)
    );

    bsa_out_reg #(
        .DF          (DF),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_out (
        .clk        (par_clk),
        .rst        (rst),
        .hold       (hold),
        .ready_flip (ready_flip),
        .word_out   (word_out),
        .word_upd   (word_upd)
    );

endmodule

// File: rtl/bsa_chk.sv
module bsa_chk
    import bsa_pkg::*;
#(
    parameter int DF = 8,
    parameter int RW = 4
) (
    input logic          bit_clk,
    input logic          par_clk,
    input logic          rst,
    input logic          rollover,
    input logic          slip_rise,
    input logic [RW-1:0] slip_cnt,
    input stall_len_t    stall_left,
    input logic          word_upd,
    input logic [DF-1:0] word_out
);

    // R5
    rollover_single_chk: assert property (@(posedge par_clk) disable iff (rst)
        rollover |=> !rollover);

    // R5
    rollover_cause_chk: assert property (@(posedge par_clk) disable iff (rst)
        rollover |-> $past(slip_rise));

    // R6
    slip_cnt_range_chk: assert property (@(posedge par_clk) disable iff (rst)
        int'(slip_cnt) < DF);

    // R2
    stall_bound_chk: assert property (@(posedge bit_clk) disable iff (rst)
        int'(stall_left) < DF);

    // R9
    word_hold_chk: assert property (@(posedge par_clk) disable iff (rst)
        !word_upd |=> $stable(word_out));

endmodule

bind bsa_aligner bsa_chk #(
    .DF (DF),
    .RW (RW)
) u_bsa_chk (
    .bit_clk    (bit_clk),
    .par_clk    (par_clk),
    .rst        (rst),
    .rollover   (rollover),
    .slip_rise  (slip_rise),
    .slip_cnt   (slip_cnt),
    .stall_left (stall_left),
    .word_upd   (word_upd),
    .word_out   (word_out)
);

// File: tb/test_bsa_aligner.sv
`timescale 1ns/1ps
module test_bsa_aligner;

    localparam int DF = 8;
    localparam int RW = $clog2(DF + 1);
    localparam logic [DF-1:0] PAT = 8'h17;

    logic          bit_clk;
    logic          par_clk;
    logic          rst;
    logic          ser_in;
    logic          slip_req;
    logic [RW-1:0] roll_cnt;
    logic [DF-1:0] word_out;
    logic          rollover;

    int n_checks = 0;
    int n_fail   = 0;
    int roll_seen = 0;
    int idx = 0;
    bit done = 0;
    logic [DF-1:0] base;

    bsa_aligner #(.DF(DF)) i_bsa_aligner (
        .bit_clk  (bit_clk),
        .par_clk  (par_clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .slip_req (slip_req),
        .roll_cnt (roll_cnt),
        .word_out (word_out),
        .rollover (rollover)
    );

    // 250 MHz bit clock; parallel clock DF times slower, edges aligned
    initial begin
        bit_clk = 0;
        forever #2 bit_clk = ~bit_clk;
    end

    initial begin
        par_clk = 0;
        #2;
        forever begin
            par_clk = 1; #(2 * DF);
            par_clk = 0; #(2 * DF);
        end
    end

    // Periodic serial pattern, MSB first
    initial ser_in = 0;
    always @(negedge bit_clk) begin
        ser_in <= PAT[DF-1-idx];
        idx    <= (idx == DF - 1) ? 0 : idx + 1;
    end

    always @(negedge par_clk) if (rollover === 1'b1) roll_seen++;

    function automatic logic [DF-1:0] rotl(logic [DF-1:0] w, int k);
        for (int i = 0; i < k; i++) w = {w[DF-2:0], w[DF-1]};
        return w;
    endfunction

    function automatic int rot_index(logic [DF-1:0] w);
        for (int k = 0; k < DF; k++) if (rotl(PAT, k) === w) return k;
        return -1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_par(int n);
        repeat (n) @(negedge par_clk);
    endtask

    task automatic do_reset(int n);
        @(negedge par_clk);
        roll_cnt = RW'(n);
        rst = 1;
        wait_par(4);
        check(word_out === '0, "R8 word cleared", int'(word_out), 0);
        check(rollover === 1'b0, "R8 rollover low", int'(rollover), 0);
        rst = 0;
        wait_par(16);
        base = word_out;
        check(rot_index(base) >= 0, "R1 MSB-first framing", int'(base), int'(PAT));
    endtask

    task automatic slip(int len);
        @(negedge par_clk);
        slip_req = 1;
        wait_par(len);
        slip_req = 0;
        wait_par(16);
    endtask

    task automatic t_single();
        do_reset(DF);
        slip(1);
        check(word_out === rotl(base, 1), "R3 one-cycle slip", int'(word_out), int'(rotl(base, 1)));
        slip(1);
        check(word_out === rotl(base, 2), "R2 one bit per slip", int'(word_out), int'(rotl(base, 2)));
    endtask

    task automatic t_long();
        int r0;
        do_reset(DF);
        r0 = roll_seen;
        slip(40);
        check(word_out === rotl(base, 1), "R4 long level one slip", int'(word_out), int'(rotl(base, 1)));
        wait_par(20);
        check(word_out === rotl(base, 1), "R4 no extra slip", int'(word_out), int'(rotl(base, 1)));
        check(roll_seen == r0, "R4 no rollover", roll_seen - r0, 0);
    endtask

    task automatic t_full();
        int r0;
        do_reset(DF);
        r0 = roll_seen;
        for (int k = 1; k <= DF; k++) begin
            slip(2);
            check(word_out === rotl(base, k % DF), "R2 full cycle word", int'(word_out), int'(rotl(base, k % DF)));
            check(roll_seen - r0 == ((k == DF) ? 1 : 0), "R5 rollover count", roll_seen - r0, (k == DF) ? 1 : 0);
        end
    endtask

    task automatic t_short();
        int r0;
        do_reset(3);
        r0 = roll_seen;
        for (int k = 1; k <= 4; k++) begin
            slip(1);
            check(word_out === rotl(base, k % 3), "R6 wrap returns boundary", int'(word_out), int'(rotl(base, k % 3)));
            check(roll_seen - r0 == ((k >= 3) ? 1 : 0), "R6 rollover at third", roll_seen - r0, (k >= 3) ? 1 : 0);
        end
    endtask

    task automatic t_one();
        int r0;
        do_reset(1);
        r0 = roll_seen;
        for (int k = 1; k <= 2; k++) begin
            slip(1);
            check(word_out === base, "R7 count one keeps word", int'(word_out), int'(base));
            check(roll_seen - r0 == k, "R7 rollover every slip", roll_seen - r0, k);
        end
        do_reset(0);
        r0 = roll_seen;
        slip(1);
        check(word_out === base, "R7 zero as one word", int'(word_out), int'(base));
        check(roll_seen - r0 == 1, "R7 zero as one rollover", roll_seen - r0, 1);
    endtask

    task automatic t_midreset();
        int r0;
        do_reset(3);
        slip(1);
        slip(1);
        do_reset(3);
        r0 = roll_seen;
        slip(1);
        check(word_out === rotl(base, 1), "R8 slip after reset", int'(word_out), int'(rotl(base, 1)));
        check(roll_seen == r0, "R8 count cleared", roll_seen - r0, 0);
        slip(1);
        check(roll_seen == r0, "R8 no early rollover", roll_seen - r0, 0);
        slip(1);
        check(roll_seen - r0 == 1, "R8 rollover on third", roll_seen - r0, 1);
    endtask

    initial begin
        rst = 1;
        slip_req = 0;
        roll_cnt = RW'(DF);
        t_single();
        t_long();
        t_full();
        t_short();
        t_one();
        t_midreset();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule